// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard and bypass controller of a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback, and the pipeline has no branch delay slot. The decoder hands it the operation class and register fields of the instruction waiting in decode, plus a valid flag. The datapath reports whether the register tested by a conditional branch now in execute holds zero. An external stall input asks the front of the pipeline to pause.

Each cycle the block decides whether the decoded instruction moves into execute. It holds the fetch and decode registers while a load result is not yet available or while the external stall is active. It kills the two front instructions when a jump or a taken branch resolves in execute. Fetch assumes every branch is not taken. The controller keeps its own short record of the destination registers in execute and memory. From that record it registers the operand-source selects that the execute stage uses for its two operands.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Synchronous active-high reset empties the execute and memory records. In the first cycle after reset there is no interlock and no squash, both selects read 0, and a register source that was pending before reset is not bypassed.
- R2: The decoded instruction enters execute (`issue`=1) exactly when `id_valid`=1, `ext_stall`=0, no taken transfer is in execute and no load interlock is active. Operation codes on `id_op` are: 0 three-register ALU, 1 ALU-immediate, 2 load, 3 store, 4 jump, 5 branch-if-zero.
- R3: While `ext_stall`=1 and no transfer is taken, `hold_front`=1 and `issue`=0, so a bubble goes into execute. A jump or taken branch already in execute still raises `squash_front` during a stall, and in that cycle `hold_front`=0.
- R4: A jump in execute, or a branch in execute with `ex_src_zero`=1, sets `squash_front`=1 for that cycle. The decoded instruction becomes a bubble and is never used as a forwarding source.
- R5: A branch in execute with `ex_src_zero`=0 causes no squash. `ex_src_zero` has no effect when the instruction in execute is not a branch.
- R6: When a load that writes a nonzero register is in execute and the decoded instruction reads that register, `load_interlock`=1 and `hold_front`=1 for one cycle. The reads that count are source 1 for ALU, ALU-immediate, load, store and branch, and source 2 for three-register ALU and store only.
- R7: A select is registered when its instruction enters execute and is valid during that instruction's execute cycle. The codes are 0 register file, 1 memory-stage result, 2 writeback-stage result. When both later stages write the source register, the memory stage wins. A bubble entering execute gets 0 on both selects.
- R8: No bypass is selected for register 0, for an operand the operation does not read, or from a store, branch, jump or bubble.
- R9: The data operand of a store (source 2) is bypassed under the same rules as ALU sources.
- R10: An interlock never lasts two consecutive cycles. With `ext_stall`=0, a valid decoded instruction issues or is squashed within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_stall | input | 1 | Request to hold the front of the pipeline |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_op | input | 3 | Operation class of the decoded instruction |
| id_rd | input | REG_W | Destination register of the decoded instruction |
| id_rs1 | input | REG_W | First source register of the decoded instruction |
| id_rs2 | input | REG_W | Second source register of the decoded instruction |
| ex_src_zero | input | 1 | Register tested by the execute-stage instruction equals zero |
| issue | output | 1 | Decoded instruction enters execute this cycle |
| hold_front | output | 1 | Fetch and decode registers keep their contents |
| squash_front | output | 1 | Fetch and decode are killed and fetch is redirected |
| load_interlock | output | 1 | Load-use hazard detected this cycle |
| fwd_a_sel | output | 2 | Source select for execute operand 1 |
| fwd_b_sel | output | 2 | Source select for execute operand 2 |

## Verification
The stimulus is one continuous instruction stream. Its back-to-back dependent ALU pairs select the memory stage, and pairs one slot apart select writeback. A case where both later stages write the same register separates the priority order from a plain match. Load-use pairs on source 1 and on a store's data operand separate a real interlock from a near miss, such as a load into register 0 or an ALU-immediate whose unused second field names the load target. Taken and not-taken branches, a jump under external stall, and a consumer of a squashed instruction's register separate redirect, squash and hold. They also show that killed instructions leave no forwarding trace. Reset is applied with a load pending, to show that the interlock record is cleared.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [2:0] {
    OP_ALU_R  = 3'd0,
    OP_ALU_I  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_JUMP   = 3'd4,
    OP_BRANCH = 3'd5
  } hz_op_e;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } hz_fwd_e;

  localparam int unsigned NUM_SRC = 2;

  // Which register fields an operation actually reads (idx 0 = rs1, 1 = rs2)
  function automatic logic op_reads(input logic [2:0] op, input int idx);
    logic r;
    case (hz_op_e'(op))
      OP_ALU_R:  r = 1'b1;
      OP_STORE:  r = 1'b1;
      OP_ALU_I,
      OP_LOAD,
      OP_BRANCH: r = (idx == 0);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic op_writes(input logic [2:0] op);
    logic w;
    case (hz_op_e'(op))
      OP_ALU_R, OP_ALU_I, OP_LOAD: w = 1'b1;
      default:                     w = 1'b0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [2:0]       id_op,
  input  logic [REG_W-1:0] id_rd,
  output logic             ex_valid,
  output logic [2:0]       ex_op,
  output logic [REG_W-1:0] ex_rd,
  output logic             ex_wen,
  output logic [REG_W-1:0] mem_rd,
  output logic             mem_wen
);
  import hz_pkg::*;

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic id_wen;
  assign id_wen = issue && op_writes(id_op) && (id_rd != ZERO_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_op    <= OP_ALU_R;
      ex_rd    <= '0;
      ex_wen   <= 1'b0;
      mem_rd   <= '0;
      mem_wen  <= 1'b0;
    end else begin
      ex_valid <= issue;
      ex_op    <= id_op;
      ex_rd    <= id_rd;
      ex_wen   <= id_wen;
      mem_rd   <= ex_rd;
      mem_wen  <= ex_wen;
    end
  end
endmodule

// File: rtl/hz_issue_ctrl.sv
module hz_issue_ctrl #(
  parameter int unsigned REG_W = 5
) (
  input  logic             ext_stall,
  input  logic             id_valid,
  input  logic [2:0]       id_op,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             ex_valid,
  input  logic [2:0]       ex_op,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_src_zero,
  output logic             taken,
  output logic             interlock,
  output logic             issue,
  output logic             hold_front
);
  import hz_pkg::*;

  logic ex_is_load, hit1, hit2;

  always_comb begin
    ex_is_load = ex_valid && (hz_op_e'(ex_op) == OP_LOAD);
    taken      = ex_valid && ((hz_op_e'(ex_op) == OP_JUMP) ||
                              ((hz_op_e'(ex_op) == OP_BRANCH) && ex_src_zero));
    hit1       = op_reads(id_op, 0) && (id_rs1 == ex_rd);
    hit2       = op_reads(id_op, 1) && (id_rs2 == ex_rd);
    interlock  = id_valid && ex_is_load && ex_wen && (hit1 || hit2);
    issue      = id_valid && !ext_stall && !taken && !interlock;
    hold_front = !taken && (ext_stall || interlock);
  end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             src_used,
  input  logic [REG_W-1:0] src,
  input  logic             ex_wen,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_rd,
  output logic [1:0]       sel
);
  import hz_pkg::*;

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  hz_fwd_e nxt;

  always_comb begin
    nxt = FWD_RF;
    if (issue && src_used && (src != ZERO_REG)) begin
      if (ex_wen && (ex_rd == src))        nxt = FWD_MEM;
      else if (mem_wen && (mem_rd == src)) nxt = FWD_WB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel <= FWD_RF;
    else     sel <= nxt;
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_stall,
  input  logic             id_valid,
  input  logic [2:0]       id_op,
  input  logic [REG_W-1:0] id_rd,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             ex_src_zero,
  output logic             issue,
  output logic             hold_front,
  output logic             squash_front,
  output logic             load_interlock,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel
);
  import hz_pkg::*;

  logic             ex_valid, ex_wen, mem_wen, taken;
  logic [2:0]       ex_op;
  logic [REG_W-1:0] ex_rd, mem_rd;
  logic [REG_W-1:0] src_reg [NUM_SRC];
  logic [1:0]       src_sel [NUM_SRC];

  assign src_reg[0] = id_rs1;
  assign src_reg[1] = id_rs2;

  hz_stage_track #(.REG_W(REG_W)) track_i (
    .clk(clk), .rst(rst), .issue(issue), .id_op(id_op), .id_rd(id_rd),
    .ex_valid(ex_valid), .ex_op(ex_op), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .mem_rd(mem_rd), .mem_wen(mem_wen)
  );

  hz_issue_ctrl #(.REG_W(REG_W)) ctrl_i (
    .ext_stall(ext_stall), .id_valid(id_valid), .id_op(id_op),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_valid(ex_valid), .ex_op(ex_op),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_src_zero(ex_src_zero),
    .taken(taken), .interlock(load_interlock), .issue(issue),
    .hold_front(hold_front)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hz_fwd_pick #(.REG_W(REG_W)) pick_i (
      .clk(clk), .rst(rst), .issue(issue),
      .src_used(op_reads(id_op, g)), .src(src_reg[g]),
      .ex_wen(ex_wen), .ex_rd(ex_rd), .mem_wen(mem_wen), .mem_rd(mem_rd),
      .sel(src_sel[g])
    );
  end

  assign squash_front = taken;
  assign fwd_a_sel    = src_sel[0];
  assign fwd_b_sel    = src_sel[1];
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_stall,
  input logic       id_valid,
  input logic       issue,
  input logic       hold_front,
  input logic       squash_front,
  input logic       load_interlock,
  input logic [1:0] fwd_a_sel,
  input logic [1:0] fwd_b_sel
);
  assert_stall_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    ext_stall |-> !issue);

  assert_squash_bubble_R4: assert property (@(posedge clk) disable iff (rst)
    squash_front |=> (!squash_front && !load_interlock));

  assert_bubble_selects_R7: assert property (@(posedge clk) disable iff (rst)
    !issue |=> (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0));

  assert_sel_code_R7: assert property (@(posedge clk) disable iff (rst)
    (fwd_a_sel != 2'd3) && (fwd_b_sel != 2'd3));

  assert_interlock_single_R10: assert property (@(posedge clk) disable iff (rst)
    load_interlock |=> !load_interlock);

  assert_hold_released_R10: assert property (@(posedge clk) disable iff (rst)
    (hold_front && !ext_stall) |=> (!hold_front || ext_stall));

  assert_progress_R10: assert property (@(posedge clk) disable iff (rst)
    (!ext_stall && id_valid && !issue && !squash_front) |=>
      (ext_stall || !id_valid || issue || squash_front));
endmodule

bind pipe_hazard_ctrl hz_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .ext_stall(ext_stall), .id_valid(id_valid),
  .issue(issue), .hold_front(hold_front), .squash_front(squash_front),
  .load_interlock(load_interlock), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel)
);

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb_top;
  import hz_pkg::*;

  localparam int unsigned RW = 5;
  localparam int unsigned NV = 33;

  typedef struct packed {
    logic          stall, zero, valid;
    logic [2:0]    op;
    logic [RW-1:0] rd, rs1, rs2;
    logic          e_issue, e_hold, e_sq, e_ilk;
    logic [1:0]    e_fa, e_fb;
    logic [3:0]    req;
  } vec_t;

  function automatic vec_t v(input logic st, input logic z, input logic vl,
                             input hz_op_e op, input int rd, input int r1, input int r2,
                             input logic ei, input logic eh, input logic es, input logic el,
                             input int fa, input int fb, input int rq);
    vec_t x;
    x.stall = st; x.zero = z; x.valid = vl; x.op = op;
    x.rd = RW'(rd); x.rs1 = RW'(r1); x.rs2 = RW'(r2);
    x.e_issue = ei; x.e_hold = eh; x.e_sq = es; x.e_ilk = el;
    x.e_fa = 2'(fa); x.e_fb = 2'(fb); x.req = 4'(rq);
    return x;
  endfunction

  localparam vec_t VECS [NV] = '{
    v(0,0,1,OP_ALU_R, 1, 2, 3, 1,0,0,0, 0,0, 2),
    v(0,0,1,OP_ALU_R, 4, 1, 1, 1,0,0,0, 0,0, 2),
    v(0,0,1,OP_ALU_I, 5, 1, 4, 1,0,0,0, 1,1, 7),
    v(0,0,1,OP_STORE, 0, 5, 4, 1,0,0,0, 2,0, 8),
    v(0,0,1,OP_LOAD,  6, 0, 0, 1,0,0,0, 1,2, 9),
    v(0,0,1,OP_ALU_R, 7, 6, 0, 0,1,0,1, 0,0, 6),
    v(0,0,1,OP_ALU_R, 7, 6, 0, 1,0,0,0, 0,0,10),
    v(0,1,1,OP_BRANCH,0, 7, 0, 1,0,0,0, 2,0, 5),
    v(0,0,1,OP_ALU_R, 8, 1, 2, 1,0,0,0, 1,0, 5),
    v(0,1,1,OP_ALU_R, 9, 8, 0, 1,0,0,0, 0,0, 5),
    v(0,0,1,OP_BRANCH,0, 9, 0, 1,0,0,0, 1,0, 7),
    v(0,1,1,OP_ALU_R,10, 1, 1, 0,0,1,0, 1,0, 4),
    v(0,0,1,OP_ALU_R,11,10,10, 1,0,0,0, 0,0, 4),
    v(0,0,1,OP_JUMP,  0, 0, 0, 1,0,0,0, 0,0, 4),
    v(1,0,1,OP_ALU_R,12,11, 0, 0,0,1,0, 0,0, 3),
    v(1,0,1,OP_ALU_R,12,11, 0, 0,1,0,0, 0,0, 3),
    v(0,0,1,OP_ALU_R,12,11, 0, 1,0,0,0, 0,0, 3),
    v(0,0,1,OP_ALU_R, 0,12,12, 1,0,0,0, 0,0, 8),
    v(0,0,1,OP_ALU_R,13, 0,12, 1,0,0,0, 1,1, 7),
    v(0,0,1,OP_LOAD,  0,13, 0, 1,0,0,0, 0,2, 8),
    v(0,0,1,OP_ALU_R,14, 0, 0, 1,0,0,0, 1,0, 8),
    v(0,0,1,OP_ALU_R,15, 2, 2, 1,0,0,0, 0,0, 8),
    v(0,0,1,OP_ALU_I,15, 3, 0, 1,0,0,0, 0,0, 7),
    v(0,0,1,OP_ALU_R,16,15,15, 1,0,0,0, 0,0, 7),
    v(0,0,0,OP_ALU_R, 0, 0, 0, 0,0,0,0, 1,1, 7),
    v(0,0,0,OP_ALU_R, 0, 0, 0, 0,0,0,0, 0,0, 2),
    v(0,0,1,OP_LOAD, 20, 0, 0, 1,0,0,0, 0,0, 6),
    v(0,0,1,OP_STORE, 0, 0,20, 0,1,0,1, 0,0, 6),
    v(0,0,1,OP_STORE, 0, 0,20, 1,0,0,0, 0,0,10),
    v(0,0,0,OP_ALU_R, 0, 0, 0, 0,0,0,0, 0,2, 9),
    v(0,0,1,OP_LOAD, 21, 0, 0, 1,0,0,0, 0,0, 6),
    v(0,0,1,OP_ALU_I,22, 1,21, 1,0,0,0, 0,0, 6),
    v(0,0,0,OP_ALU_R, 0, 0, 0, 0,0,0,0, 0,0, 8)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_stall = 1'b0, id_valid = 1'b0, ex_src_zero = 1'b0;
  logic [2:0]    id_op = '0;
  logic [RW-1:0] id_rd = '0, id_rs1 = '0, id_rs2 = '0;
  logic issue, hold_front, squash_front, load_interlock;
  logic [1:0] fwd_a_sel, fwd_b_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pipe_hazard_ctrl #(.REG_W(RW)) dut_i (
    .clk(clk), .rst(rst), .ext_stall(ext_stall), .id_valid(id_valid),
    .id_op(id_op), .id_rd(id_rd), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_src_zero(ex_src_zero), .issue(issue), .hold_front(hold_front),
    .squash_front(squash_front), .load_interlock(load_interlock),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel)
  );

  function automatic string tag(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic st, input logic z, input logic vl, input logic [2:0] op,
                       input int rd, input int r1, input int r2);
    ext_stall = st; ex_src_zero = z; id_valid = vl; id_op = op;
    id_rd = RW'(rd); id_rs1 = RW'(r1); id_rs2 = RW'(r2);
  endtask

  initial begin
    int holds, squashes, exp_holds, exp_sq;
    holds = 0; squashes = 0; exp_holds = 0; exp_sq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #4;
    // R1: state right after reset
    chk("R1", "issue", int'(issue), 0);
    chk("R1", "squash", int'(squash_front), 0);
    chk("R1", "interlock", int'(load_interlock), 0);
    chk("R1", "fwd_a", int'(fwd_a_sel), 0);
    chk("R1", "fwd_b", int'(fwd_b_sel), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].stall, VECS[i].zero, VECS[i].valid, VECS[i].op,
            int'(VECS[i].rd), int'(VECS[i].rs1), int'(VECS[i].rs2));
      #4;
      chk(tag(int'(VECS[i].req)), "issue", int'(issue), int'(VECS[i].e_issue));
      chk(tag(int'(VECS[i].req)), "hold", int'(hold_front), int'(VECS[i].e_hold));
      chk(tag(int'(VECS[i].req)), "squash", int'(squash_front), int'(VECS[i].e_sq));
      chk(tag(int'(VECS[i].req)), "interlock", int'(load_interlock), int'(VECS[i].e_ilk));
      chk(tag(int'(VECS[i].req)), "fwd_a", int'(fwd_a_sel), int'(VECS[i].e_fa));
      chk(tag(int'(VECS[i].req)), "fwd_b", int'(fwd_b_sel), int'(VECS[i].e_fb));
      holds += int'(hold_front);
      squashes += int'(squash_front);
      exp_holds += int'(VECS[i].e_hold);
      exp_sq += int'(VECS[i].e_sq);
    end
    chk("R6", "hold cycle count", holds, exp_holds);
    chk("R4", "squash cycle count", squashes, exp_sq);

    // R3: stall with an empty decode stage still holds the front
    @(negedge clk);
    drive(1, 0, 0, OP_ALU_R, 0, 0, 0);
    #4;
    chk("R3", "hold empty", int'(hold_front), 1);
    chk("R3", "issue empty", int'(issue), 0);

    // R1: reset clears a pending load so the consumer is not interlocked
    @(negedge clk);
    drive(0, 0, 1, OP_LOAD, 5, 0, 0);
    #4;
    chk("R1", "load issue", int'(issue), 1);
    @(negedge clk);
    rst = 1'b1;
    drive(0, 0, 1, OP_ALU_R, 6, 5, 5);
    @(negedge clk);
    rst = 1'b0;
    #4;
    chk("R1", "interlock after reset", int'(load_interlock), 0);
    chk("R1", "issue after reset", int'(issue), 1);
    @(negedge clk);
    drive(0, 0, 0, OP_ALU_R, 0, 0, 0);
    #4;
    chk("R1", "fwd_a after reset", int'(fwd_a_sel), 0);
    chk("R1", "fwd_b after reset", int'(fwd_b_sel), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule